// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream for one read or write burst of a synchronous DRAM, one address per clock. A start pulse loads the first column and latches the burst settings (length code, ordering, whether the access is a write, and a single-word-write option). While the burst runs, the block emits successive columns in either linear-wrap or XOR (interleaved) order inside the block of columns aligned to the burst length. A page-length setting keeps counting through all 256 columns until it is halted.

A controller pulses the start input for each read or write command and the stop input for a burst-terminate command. A start pulse on any cycle replaces the running burst, including the last cycle of a finite burst, so consecutive bursts run with no idle cycle between them. While no burst is running, the column output keeps the last address issued. Row and bank selection and the data path belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous reset with rst_n low, active_o is 0 and col_o is 0.
- R2: A start pulse sampled at a clock edge makes active_o 1 and col_o equal to start_col_i from that edge on; the length code, ordering, write flag and single-write option are captured at that same edge and later changes to them are ignored for that burst.
- R3: With interleave_i low and length code 0, 1, 2 or 3 (lengths 1, 2, 4 and 8), the low log2(length) bits of col_o count upward by one per clock and wrap inside the length-aligned block, while the higher bits stay equal to those of the start column.
- R4: With interleave_i high and length code 0 to 3, the address on step i of the burst (step 0 being the start column) equals the start column XOR i.
- R5: A finite burst keeps active_o high for exactly as many clocks as its length and then drops it; while idle, col_o keeps the last address issued.
- R6: Length code 7 with interleave_i low is a page burst: col_o increases by one per clock modulo 256 and active_o stays high until a stop or a new start.
- R7: Length code 7 with interleave_i high, and the unused codes 4, 5 and 6, give a one-address burst.
- R8: A stop pulse with no start pulse clears active_o at the next edge and col_o keeps its value; when stop and start arrive together, the start wins.
- R9: A start pulse during a running burst abandons it: from the next edge col_o shows the new start column and the new burst runs its full length.
- R10: A start pulse in the last cycle of a finite burst begins the next burst with active_o staying high, with no idle cycle.
- R11: When single_wr_i and start_wr_i are both high at the start, the burst has length 1 whatever the length code; with start_wr_i low the programmed length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Read or write command pulse; loads a new burst |
| start_col_i | input | 8 | First column of the new burst |
| start_wr_i | input | 1 | The command is a write |
| len_code_i | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=page, others=1 |
| interleave_i | input | 1 | 1 selects XOR ordering, 0 linear wrap |
| single_wr_i | input | 1 | Writes use one address regardless of length |
| stop_i | input | 1 | Burst-terminate pulse |
| col_o | output | 8 | Current column address |
| active_o | output | 1 | A burst is issuing addresses |

## Verification
The directed scenarios start bursts from a column whose low bits are not zero, so a sequencer that counted without wrapping would carry into the upper bits and one that reset the low bits to zero would start at the wrong column. The page burst runs past column 255, which catches an address that saturates or a flag that ends after 256 steps. A start pulse is placed in the last cycle of a burst and in the middle of a burst, where a design that gave priority to the ending count or to stop would insert a gap or finish the old burst. Page length with interleave, the spare codes and single-word writes are checked for a single address, where a faulty decode would run eight or 256 addresses.

// File: rtl/burst_col_pkg.sv
// Package: shared length encodings for the burst column sequencer.
// Assumes a 3-bit length code where 0..3 select powers of two.
package burst_col_pkg;
    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } burst_len_e;

    localparam int LEN_CODE_W = 3;
endpackage

// File: rtl/burst_len_decode.sv
// Turns the length code and options into a low-bit mask and a page flag.
// Assumes COL_W >= 4 so masks up to length 8 fit. Pure combinational.
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  interleave_i,
    input  logic                  wr_i,
    input  logic                  single_wr_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  page_o
);
    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    // Map the code to the mask of bits that move during the burst.
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        if (!(single_wr_i && wr_i)) begin
            case (code_i)
                LEN_1:    mask_o = COL_W'(0);
                LEN_2:    mask_o = COL_W'(1);
                LEN_4:    mask_o = COL_W'(3);
                LEN_8:    mask_o = COL_W'(7);
                LEN_PAGE: begin
                    if (!interleave_i) begin
                        mask_o = ALL_ONES;
                        page_o = 1'b1;
                    end
                end
                default:  mask_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_step_ctrl.sv
// Holds the burst state: active flag, step counter and latched length.
// Start has priority over stop; a finite burst ends after step == mask.
module burst_step_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    output logic             active_o,
    output logic [COL_W-1:0] step_o,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    logic at_end;

    // Flag the final step of a finite burst.
    always_comb at_end = active_o && !page_o && (step_o == mask_o);

    // Advance, reload or stop the burst on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            step_o   <= '0;
            mask_o   <= '0;
            page_o   <= 1'b0;
        end else if (start_i) begin
            active_o <= 1'b1;
            step_o   <= '0;
            mask_o   <= mask_i;
            page_o   <= page_i;
        end else if (stop_i) begin
            active_o <= 1'b0;
        end else if (active_o) begin
            if (at_end) active_o <= 1'b0;
            else        step_o   <= step_o + COL_W'(1);
        end
    end

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && step_o == '0));
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !active_o);
    assert_finite_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !page_o && step_o == mask_o && !start_i) |=> !active_o);
    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !page_o) |-> (step_o <= mask_o));
    assert_page_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && page_o && !start_i && !stop_i) |=> active_o);
endmodule

// File: rtl/burst_addr_map.sv
// Latches the start column and ordering, and forms the column for each step.
// Assumes step stays within mask for finite bursts (guaranteed by the controller).
module burst_addr_map #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             interleave_i,
    input  logic             active_i,
    input  logic [COL_W-1:0] step_i,
    input  logic [COL_W-1:0] mask_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] base_q;
    logic             xor_q;
    logic [COL_W-1:0] lin_sum;

    // Capture the start column and ordering with each new burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            xor_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            xor_q  <= interleave_i;
        end
    end

    // Combine base and step in linear-wrap or XOR order.
    always_comb begin
        lin_sum = base_q + step_i;
        if (xor_q) col_o = base_q ^ step_i;
        else       col_o = (base_q & ~mask_i) | (lin_sum & mask_i);
    end

    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ((col_o & ~mask_i) == (base_q & ~mask_i)));
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !start_i) |=> $stable(col_o));
endmodule

// File: rtl/burst_col_seq.sv
// Top: column address sequencer for one DRAM burst, one address per clock.
// Assumes start and stop are single-cycle command pulses.
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic                  start_wr_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  interleave_i,
    input  logic                  single_wr_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  active_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] step;
    logic [COL_W-1:0] mask_q;
    logic             page_q;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i       (len_code_i),
        .interleave_i (interleave_i),
        .wr_i         (start_wr_i),
        .single_wr_i  (single_wr_i),
        .mask_o       (dec_mask),
        .page_o       (dec_page)
    );

    burst_step_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .mask_i   (dec_mask),
        .page_i   (dec_page),
        .active_o (active_o),
        .step_o   (step),
        .mask_o   (mask_q),
        .page_o   (page_q)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .interleave_i (interleave_i),
        .active_i     (active_o),
        .step_i       (step),
        .mask_i       (mask_q),
        .col_o        (col_o)
    );

    assert_page_increment_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && page_q && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1)));
    assert_start_column_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(start_col_i)));
endmodule

// File: tb/burst_col_seq_test.sv
// Directed bench: one task per scenario, each checking its own results.
module burst_col_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic       start_wr_i = 1'b0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       active_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .start_wr_i(start_wr_i), .len_code_i(len_code_i), .interleave_i(interleave_i),
        .single_wr_i(single_wr_i), .stop_i(stop_i), .col_o(col_o), .active_o(active_o)
    );

    function automatic logic [7:0] exp_col(logic [7:0] b, int len, bit il, int i);
        logic [7:0] m = 8'(len - 1);
        logic [7:0] k = 8'(i % len);
        if (il) return b ^ k;
        return (b & ~m) | (8'(b + k) & m);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive a start pulse at a negedge; returns one negedge later (step 0 visible).
    task automatic issue(logic [7:0] b, logic [2:0] code, bit il, bit wr, bit sw);
        start_i = 1'b1; start_col_i = b; len_code_i = code;
        interleave_i = il; start_wr_i = wr; single_wr_i = sw;
        @(negedge clk);
        start_i = 1'b0;
        // change settings after the start edge: must be ignored (R2)
        len_code_i = ~code; interleave_i = ~il; start_col_i = ~b;
    endtask

    task automatic expect_steps(string tag, logic [7:0] b, int len, bit il, int from, int cnt);
        for (int i = from; i < from + cnt; i++) begin
            check({tag, " active"}, active_o, 1);
            check({tag, " col"}, col_o, exp_col(b, len, il, i));
            @(negedge clk);
        end
    endtask

    task automatic expect_idle(string tag, logic [7:0] last);
        check({tag, " idle"}, active_o, 0);
        check({tag, " hold"}, col_o, last);
    endtask

    task automatic t_reset();
        check("R1 active", active_o, 0);
        check("R1 col", col_o, 0);
    endtask

    task automatic t_seq();
        for (int c = 0; c < 4; c++) begin
            int len = 1 << c;
            issue(8'h5D, 3'(c), 1'b0, 1'b0, 1'b0);
            expect_steps("R3 R2 seq", 8'h5D, len, 1'b0, 0, len);
            expect_idle("R5 seq", exp_col(8'h5D, len, 1'b0, len - 1));
        end
    endtask

    task automatic t_ilv();
        for (int c = 1; c < 4; c++) begin
            int len = 1 << c;
            issue(8'hA6, 3'(c), 1'b1, 1'b0, 1'b0);
            expect_steps("R4 ilv", 8'hA6, len, 1'b1, 0, len);
            expect_idle("R5 ilv", exp_col(8'hA6, len, 1'b1, len - 1));
        end
    endtask

    task automatic t_page();
        issue(8'hFD, 3'd7, 1'b0, 1'b0, 1'b0);
        expect_steps("R6 page", 8'hFD, 256, 1'b0, 0, 260);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        expect_idle("R8 stop", exp_col(8'hFD, 256, 1'b0, 260));
        @(negedge clk);
        expect_idle("R8 stop later", exp_col(8'hFD, 256, 1'b0, 260));
    endtask

    task automatic t_single_addr();
        issue(8'h33, 3'd7, 1'b1, 1'b0, 1'b0);
        expect_steps("R7 page+ilv", 8'h33, 1, 1'b0, 0, 1);
        expect_idle("R7 page+ilv", 8'h33);
        issue(8'h44, 3'd5, 1'b0, 1'b0, 1'b0);
        expect_steps("R7 spare code", 8'h44, 1, 1'b0, 0, 1);
        expect_idle("R7 spare code", 8'h44);
    endtask

    task automatic t_single_wr();
        issue(8'h12, 3'd3, 1'b0, 1'b1, 1'b1);
        expect_steps("R11 write", 8'h12, 1, 1'b0, 0, 1);
        expect_idle("R11 write", 8'h12);
        issue(8'h12, 3'd3, 1'b0, 1'b0, 1'b1);
        expect_steps("R11 read", 8'h12, 8, 1'b0, 0, 8);
        expect_idle("R11 read", exp_col(8'h12, 8, 1'b0, 7));
    endtask

    task automatic t_restart();
        issue(8'h16, 3'd3, 1'b0, 1'b0, 1'b0);
        expect_steps("R9 first", 8'h16, 8, 1'b0, 0, 3);
        issue(8'h83, 3'd2, 1'b1, 1'b0, 1'b0);
        expect_steps("R9 second", 8'h83, 4, 1'b1, 0, 4);
        expect_idle("R9 end", exp_col(8'h83, 4, 1'b1, 3));
    endtask

    task automatic t_back_to_back();
        issue(8'h21, 3'd1, 1'b0, 1'b0, 1'b0);
        expect_steps("R10 first", 8'h21, 2, 1'b0, 0, 1);
        check("R10 last step", col_o, 8'h20);
        issue(8'h47, 3'd2, 1'b0, 1'b0, 1'b0);
        expect_steps("R10 second", 8'h47, 4, 1'b0, 0, 4);
        expect_idle("R10 end", exp_col(8'h47, 4, 1'b0, 3));
    endtask

    task automatic t_stop_and_start();
        issue(8'h60, 3'd3, 1'b0, 1'b0, 1'b0);
        expect_steps("R8 pre", 8'h60, 8, 1'b0, 0, 2);
        stop_i = 1'b1;
        issue(8'h9B, 3'd1, 1'b0, 1'b0, 1'b0);
        stop_i = 1'b0;
        expect_steps("R8 start wins", 8'h9B, 2, 1'b0, 0, 2);
        expect_idle("R8 start wins", exp_col(8'h9B, 2, 1'b0, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_ilv();
        t_page();
        t_single_addr();
        t_single_wr();
        t_restart();
        t_back_to_back();
        t_stop_and_start();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule